// File: doc/BRIEF.md
# Receive Packet Error-Drop Filter

This block sits between a wide receive datapath and an application packet buffer. Each input beat carries up to eight 64-bit words. With each beat come a valid-word count, a start-of-packet flag, a channel number, a 4-bit end field and an error flag. The block writes every packet into a circular beat store and adds up its byte length as the beats arrive. When the final beat arrives, it makes one decision for the whole packet. A clean packet is committed and then replayed at the output one beat per cycle, tagged with its channel and byte length. A packet that carried an error, was cut short by a new start, or did not fit in the store is removed by moving the write position back, so none of its beats ever reaches the output.

The application therefore sees only complete, clean packets, in the order they were received. Three counters and a one-cycle pulse report the drop decisions so that a test environment can account for every packet.

Top module: `pkt_err_filter`

## Requirements
- R1: After synchronous reset, `out_valid` and `proto_err` are low and `good_cnt`, `drop_cnt` and `ovf_cnt` are zero.
- R2: A released packet's `out_len`, shown on its last output beat, equals 8 bytes for every valid word before the final word, plus the final word's byte count. That byte count is `in_eop[2:0]`, where 3'b000 means 8. Example: beats of 8, 8 and 7 words with a final count of 3 give 179.
- R3: A released packet's beats leave in arrival order, with the same data and `out_nwords`. `out_sop` is set on the first beat only and `out_eop` on the last beat only. `out_chan` holds the channel sampled on the start beat.
- R4: If `in_err` is high on any beat of a packet, that packet produces no output beat and `drop_cnt` rises by one.
- R5: A beat with `in_nwords` = 0 is idle. Its start, end, error and channel fields are ignored, and it changes neither the length nor the packet state.
- R6: A start beat that arrives while a packet is open raises `proto_err` for one cycle, drops the open packet with `drop_cnt` +1, and opens the new packet normally.
- R7: A packet with more than `MAX_BEATS` beats produces no output and raises `ovf_cnt` by one, not `drop_cnt`.
- R8: `good_cnt` rises by exactly one for each packet that is released.
- R9: A non-idle beat without start-of-packet that arrives while no packet is open is ignored.
- R10: Released packets come out in receive order, with their beats on consecutive cycles, even when the next packet is being received or dropped during the replay.

Ports use an end field `in_eop` in which bit 3 marks the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sop | input | 1 | Start of packet on this beat |
| in_chan | input | CHW | Channel, sampled on the start beat |
| in_nwords | input | NWW | Valid words in beat (0 = idle) |
| in_data | input | NWORDS*WORDW | Beat data |
| in_eop | input | TW+1 | Bit 3 final beat; bits 2:0 final-word byte count |
| in_err | input | 1 | Packet error flag |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat of released packet |
| out_eop | output | 1 | Last beat of released packet |
| out_chan | output | CHW | Channel of released packet |
| out_len | output | LENW | Packet byte length, valid with `out_eop` |
| out_nwords | output | NWW | Valid words in output beat |
| out_data | output | NWORDS*WORDW | Output beat data |
| proto_err | output | 1 | Pulse: open packet aborted by new start |
| good_cnt | output | CNTW | Released packets |
| drop_cnt | output | CNTW | Packets dropped for error or abort |
| ovf_cnt | output | CNTW | Packets dropped for exceeding the store |

## Verification
A replay and a drop can happen in the same cycles. The store is read to replay a committed packet while the next packet is being written and then thrown away, which moves the write position back over entries next to the ones still being read. The bench provokes this by sending a clean four-beat packet, then an errored packet, then a one-beat packet, with no gaps between them. It judges the result by checking that exactly the two clean packets appear, with intact data, the correct lengths, consecutive beats and their original order. A second overlap is an abort that arrives on a beat that also ends the new packet with an error; that beat must add two to the drop count at once.

// File: rtl/pef_pkg.sv
package pef_pkg;
  // outcome of a packet when its final beat is taken
  typedef enum logic [1:0] {
    END_GOOD = 2'd0,
    END_ERR  = 2'd1,
    END_OVF  = 2'd2
  } pef_end_e;
endpackage

// File: rtl/pef_beat_bytes.sv
module pef_beat_bytes #(
  parameter int NWW  = 4,
  parameter int BPW  = 8,
  parameter int TW   = 3,
  parameter int LENW = 10
) (
  input  logic [NWW-1:0]  nwords,
  input  logic            last,
  input  logic [TW-1:0]   tail,
  output logic [LENW-1:0] bytes
);
  logic [LENW-1:0] tail_b;

  always_comb begin
    tail_b = (tail == '0) ? LENW'(BPW) : LENW'(tail);
    if (nwords == '0)
      bytes = '0;
    else if (last)
      bytes = LENW'(nwords - 1'b1) * LENW'(BPW) + tail_b;
    else
      bytes = LENW'(nwords) * LENW'(BPW);
  end
endmodule

// File: rtl/pef_beat_ram.sv
module pef_beat_ram #(
  parameter int W  = 518,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pef_desc_fifo.sv
module pef_desc_fifo #(
  parameter int W  = 18,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign head = slot[rp];
endmodule

// File: rtl/pkt_err_filter.sv
module pkt_err_filter #(
  parameter int NWORDS    = 8,
  parameter int WORDW     = 64,
  parameter int CHW       = 8,
  parameter int MAX_BEATS = 8,
  parameter int CNTW      = 16,
  localparam int NWW  = $clog2(NWORDS + 1),
  localparam int BPW  = WORDW / 8,
  localparam int TW   = $clog2(BPW),
  localparam int DW   = NWORDS * WORDW,
  localparam int LENW = $clog2(MAX_BEATS * NWORDS * BPW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_sop,
  input  logic [CHW-1:0]  in_chan,
  input  logic [NWW-1:0]  in_nwords,
  input  logic [DW-1:0]   in_data,
  input  logic [TW:0]     in_eop,
  input  logic            in_err,
  output logic            out_valid,
  output logic            out_sop,
  output logic            out_eop,
  output logic [CHW-1:0]  out_chan,
  output logic [LENW-1:0] out_len,
  output logic [NWW-1:0]  out_nwords,
  output logic [DW-1:0]   out_data,
  output logic            proto_err,
  output logic [CNTW-1:0] good_cnt,
  output logic [CNTW-1:0] drop_cnt,
  output logic [CNTW-1:0] ovf_cnt
);
  import pef_pkg::*;

  localparam int AW  = $clog2(2 * MAX_BEATS);
  localparam int BCW = $clog2(MAX_BEATS + 1);
  localparam int EW  = DW + NWW + 2;
  localparam int QW  = CHW + LENW;

  // open-packet state
  logic            open_q, err_q, ovf_q;
  logic [BCW-1:0]  cnt_q;
  logic [LENW-1:0] len_q;
  logic [CHW-1:0]  chan_q;
  logic [AW:0]     base_q, rd_q;

  logic            act, start, cont, take, room, last, finish, abort;
  logic [BCW-1:0]  cur_cnt;
  logic [LENW-1:0] cur_len, nxt_len, bb;
  logic            nxt_err, nxt_ovf;
  logic [CHW-1:0]  sel_chan;
  logic [AW-1:0]   waddr;
  pef_end_e        endk;

  pef_beat_bytes #(.NWW(NWW), .BPW(BPW), .TW(TW), .LENW(LENW)) u_bytes (
    .nwords(in_nwords), .last(in_eop[TW]), .tail(in_eop[TW-1:0]), .bytes(bb)
  );

  always_comb begin
    act      = (in_nwords != '0);
    last     = in_eop[TW];
    start    = act & in_sop;
    cont     = act & ~in_sop & open_q;
    take     = start | cont;
    abort    = start & open_q;
    cur_cnt  = start ? '0 : cnt_q;
    cur_len  = start ? '0 : len_q;
    room     = start | (cnt_q != BCW'(MAX_BEATS));
    nxt_len  = cur_len + bb;
    nxt_err  = (start ? 1'b0 : err_q) | in_err;
    nxt_ovf  = (start ? 1'b0 : ovf_q) | ~room;
    sel_chan = start ? in_chan : chan_q;
    finish   = take & last;
    waddr    = base_q[AW-1:0] + AW'(cur_cnt);
    if (nxt_ovf)      endk = END_OVF;
    else if (nxt_err) endk = END_ERR;
    else              endk = END_GOOD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      err_q     <= 1'b0;
      ovf_q     <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      chan_q    <= '0;
      base_q    <= '0;
      proto_err <= 1'b0;
      good_cnt  <= '0;
      drop_cnt  <= '0;
      ovf_cnt   <= '0;
    end else begin
      proto_err <= abort;
      if (take) begin
        open_q <= ~last;
        err_q  <= nxt_err;
        ovf_q  <= nxt_ovf;
        cnt_q  <= cur_cnt + BCW'(room);
        len_q  <= nxt_len;
        chan_q <= sel_chan;
      end
      drop_cnt <= drop_cnt + CNTW'(abort) + CNTW'(finish && endk == END_ERR);
      if (finish && endk == END_OVF)  ovf_cnt  <= ovf_cnt + 1'b1;
      if (finish && endk == END_GOOD) begin
        good_cnt <= good_cnt + 1'b1;
        base_q   <= base_q + (AW + 1)'(cur_cnt) + 1'b1;
      end
    end
  end

  // replay side: read committed entries one per cycle
  logic          avail;
  logic [EW-1:0] rdata;
  logic [QW-1:0] head;

  assign avail = (rd_q != base_q);

  pef_beat_ram #(.W(EW), .AW(AW)) u_store (
    .clk(clk), .we(take & room), .waddr(waddr),
    .wdata({start, last, in_nwords, in_data}),
    .re(avail), .raddr(rd_q[AW-1:0]), .rdata(rdata)
  );

  pef_desc_fifo #(.W(QW), .AW(AW)) u_desc (
    .clk(clk), .rst(rst),
    .push(finish && endk == END_GOOD), .din({sel_chan, nxt_len}),
    .pop(out_valid & out_eop), .head(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= avail;
      if (avail) rd_q <= rd_q + 1'b1;
    end
  end

  assign {out_sop, out_eop, out_nwords, out_data} = rdata;
  assign {out_chan, out_len} = head;
endmodule

// File: rtl/pef_chk.sv
module pef_chk #(
  parameter int NWW  = 4,
  parameter int LENW = 10,
  parameter int CNTW = 16,
  parameter int MAXB = 512
) (
  input logic            clk,
  input logic            rst,
  input logic            in_sop,
  input logic [NWW-1:0]  in_nwords,
  input logic            out_valid,
  input logic            out_sop,
  input logic            out_eop,
  input logic [LENW-1:0] out_len,
  input logic            proto_err,
  input logic [CNTW-1:0] good_cnt,
  input logic [CNTW-1:0] drop_cnt,
  input logic [CNTW-1:0] ovf_cnt
);
  logic o_open;

  always_ff @(posedge clk) begin
    if (rst) o_open <= 1'b0;
    else if (out_valid) o_open <= ~out_eop;
  end

  a_r3_sop_outside: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop |-> !o_open);
  a_r3_body_inside: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_sop |-> o_open);
  a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |-> (out_len != '0) && (out_len <= LENW'(MAXB)));
  a_r6_abort_cause: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(in_sop && (in_nwords != '0)));
  a_r8_good_step: assert property (@(posedge clk) disable iff (rst)
    good_cnt != $past(good_cnt) |-> good_cnt == $past(good_cnt) + 1'b1);
  a_r7_ovf_step: assert property (@(posedge clk) disable iff (rst)
    ovf_cnt != $past(ovf_cnt) |-> ovf_cnt == $past(ovf_cnt) + 1'b1);
  a_r4_drop_step: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt - $past(drop_cnt)) <= CNTW'(2));
endmodule

bind pkt_err_filter pef_chk #(
  .NWW(NWW), .LENW(LENW), .CNTW(CNTW), .MAXB(MAX_BEATS * NWORDS * BPW)
) u_chk (
  .clk(clk), .rst(rst), .in_sop(in_sop), .in_nwords(in_nwords),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_len(out_len),
  .proto_err(proto_err), .good_cnt(good_cnt), .drop_cnt(drop_cnt), .ovf_cnt(ovf_cnt)
);

// File: tb/pkt_err_filter_tb.sv
`timescale 1ns/1ps
module pkt_err_filter_tb;
  localparam int NWORDS = 8, WORDW = 64, CHW = 8, MAXB = 8, CNTW = 16;
  localparam int DW = NWORDS * WORDW;

  logic clk = 1'b0, rst = 1'b1;
  logic in_sop = 0, in_err = 0;
  logic [CHW-1:0] in_chan = '0;
  logic [3:0] in_nwords = '0, in_eop = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sop, out_eop, proto_err;
  logic [CHW-1:0] out_chan;
  logic [9:0] out_len;
  logic [3:0] out_nwords;
  logic [DW-1:0] out_data;
  logic [CNTW-1:0] good_cnt, drop_cnt, ovf_cnt;

  always #2 clk = ~clk;

  pkt_err_filter #(.NWORDS(NWORDS), .WORDW(WORDW), .CHW(CHW), .MAX_BEATS(MAXB), .CNTW(CNTW)) u_dut (
    .clk(clk), .rst(rst), .in_sop(in_sop), .in_chan(in_chan), .in_nwords(in_nwords),
    .in_data(in_data), .in_eop(in_eop), .in_err(in_err), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_chan(out_chan), .out_len(out_len),
    .out_nwords(out_nwords), .out_data(out_data), .proto_err(proto_err),
    .good_cnt(good_cnt), .drop_cnt(drop_cnt), .ovf_cnt(ovf_cnt)
  );

  int n_total = 0, n_bad = 0, n_proto = 0, cyc = 0;
  int e_good = 0, e_drop = 0, e_ovf = 0;
  logic [DW-1:0] g_d[$], x_d[$];
  int g_nw[$], g_ch[$], g_len[$], g_cy[$], x_nw[$], x_ch[$], x_len[$];
  bit g_s[$], g_e[$], x_s[$], x_e[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      g_d.push_back(out_data); g_nw.push_back(int'(out_nwords));
      g_s.push_back(out_sop); g_e.push_back(out_eop);
      g_ch.push_back(int'(out_chan)); g_len.push_back(int'(out_len)); g_cy.push_back(cyc);
    end
    if (proto_err) n_proto++;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(int seed, int b);
    logic [DW-1:0] v;
    for (int w = 0; w < NWORDS; w++)
      v[w*WORDW +: WORDW] = {16'(seed), 8'(b), 8'(w), 32'(seed * 7919 + b * 131 + w)};
    return v;
  endfunction

  task automatic beat(bit sop, int ch, int nw, bit lst, int tail, bit err, logic [DW-1:0] d);
    @(negedge clk);
    in_sop = sop; in_chan = CHW'(ch); in_nwords = 4'(nw);
    in_eop = {lst, 3'(tail)}; in_err = err; in_data = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) beat(1, 9, 0, 1, 5, 1, '1); // junk fields on idle beats
  endtask

  // one packet: nb beats, 8 words each except the last; errb = beat carrying error (-1 none)
  task automatic send_pkt(int ch, int nb, int lastnw, int tail, int errb, int gap, int seed);
    bit good = (errb < 0) && (nb <= MAXB);
    int len = (nb - 1) * 64 + (lastnw - 1) * 8 + ((tail == 0) ? 8 : tail);
    for (int b = 0; b < nb; b++) begin
      bit lst = (b == nb - 1);
      int nw = lst ? lastnw : 8;
      beat(b == 0, ch, nw, lst, tail, b == errb, mk(seed, b));
      if (good) begin
        x_d.push_back(mk(seed, b)); x_nw.push_back(nw); x_s.push_back(b == 0);
        x_e.push_back(lst); x_ch.push_back(ch); x_len.push_back(lst ? len : -1);
      end
      if (!lst && gap > 0) idle(gap);
    end
    if (nb > MAXB) e_ovf++;
    else if (errb >= 0) e_drop++;
    else e_good++;
  endtask

  task automatic drain_check(string req);
    idle(0);
    @(negedge clk); in_nwords = '0;
    repeat (2 * MAXB + 6) @(negedge clk);
    chk(g_d.size() == x_d.size(), req, "output beat count", g_d.size(), x_d.size());
    for (int i = 0; i < g_d.size() && i < x_d.size(); i++) begin
      chk(g_d[i] == x_d[i], req, "beat data low word", g_d[i][63:0], x_d[i][63:0]);
      chk(g_nw[i] == x_nw[i] && g_s[i] == x_s[i] && g_e[i] == x_e[i], req, "nwords/sop/eop",
          g_nw[i] * 100 + g_s[i] * 10 + g_e[i], x_nw[i] * 100 + x_s[i] * 10 + x_e[i]);
      chk(g_ch[i] == x_ch[i], req, "channel", g_ch[i], x_ch[i]);
      if (x_e[i]) chk(g_len[i] == x_len[i], "R2", "length", g_len[i], x_len[i]);
      if (!x_s[i] && i > 0) chk(g_cy[i] == g_cy[i-1] + 1, "R10", "beat spacing", g_cy[i] - g_cy[i-1], 1);
    end
    chk(int'(good_cnt) == e_good, "R8", "good_cnt", good_cnt, e_good);
    chk(int'(drop_cnt) == e_drop, "R4", "drop_cnt", drop_cnt, e_drop);
    chk(int'(ovf_cnt) == e_ovf, "R7", "ovf_cnt", ovf_cnt, e_ovf);
    g_d.delete(); g_nw.delete(); g_s.delete(); g_e.delete(); g_ch.delete(); g_len.delete(); g_cy.delete();
    x_d.delete(); x_nw.delete(); x_s.delete(); x_e.delete(); x_ch.delete(); x_len.delete();
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !proto_err, "R1", "valid/proto after reset", {out_valid, proto_err}, 0);
    chk(good_cnt == 0 && drop_cnt == 0 && ovf_cnt == 0, "R1", "counters after reset",
        good_cnt + drop_cnt + ovf_cnt, 0);
  endtask

  task automatic t_basic; // R2 R3: 179-byte packet, two idles, 139-byte packet
    send_pkt(2, 3, 7, 3, -1, 0, 11);
    idle(2);
    send_pkt(3, 3, 2, 3, -1, 0, 12);
    drain_check("R3");
  endtask

  task automatic t_error; // R4: error on last beat, then on first beat
    send_pkt(2, 3, 7, 3, 2, 0, 21);
    idle(2);
    send_pkt(4, 2, 5, 1, 0, 0, 22);
    send_pkt(5, 1, 4, 6, -1, 0, 23);
    drain_check("R4");
  endtask

  task automatic t_idle; // R5: idle beats with junk fields inside a packet, tail 0 = 8 bytes
    send_pkt(7, 3, 3, 0, -1, 2, 31);
    drain_check("R5");
  endtask

  task automatic t_abort; // R6: open packet aborted, then abort on an err+eop start beat
    int p0 = n_proto;
    beat(1, 5, 8, 0, 0, 0, mk(41, 0));
    e_drop++;
    send_pkt(6, 2, 8, 2, -1, 0, 42);
    drain_check("R6");
    chk(n_proto - p0 == 1, "R6", "proto_err pulses", n_proto - p0, 1);
    p0 = n_proto;
    beat(1, 5, 8, 0, 0, 0, mk(43, 0));
    beat(1, 6, 2, 1, 1, 1, mk(44, 0));
    e_drop += 2;
    drain_check("R6");
    chk(n_proto - p0 == 1, "R6", "proto_err pulses (eop+err beat)", n_proto - p0, 1);
  endtask

  task automatic t_overflow; // R7
    send_pkt(8, MAXB + 1, 8, 0, -1, 0, 51);
    send_pkt(8, MAXB, 8, 0, -1, 0, 52);
    drain_check("R7");
  endtask

  task automatic t_orphan; // R9: continuation beats with nothing open
    beat(0, 3, 8, 0, 0, 0, mk(61, 0));
    beat(0, 3, 4, 1, 2, 0, mk(61, 1));
    drain_check("R9");
  endtask

  task automatic t_b2b; // R10: replay overlaps an error drop
    send_pkt(1, 4, 8, 0, -1, 0, 71);
    send_pkt(2, 3, 6, 4, 1, 0, 72);
    send_pkt(3, 1, 1, 0, -1, 0, 73);
    drain_check("R10");
  endtask

  initial begin
    #800000;
    n_total++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_error();
    t_idle();
    t_abort();
    t_overflow();
    t_orphan();
    t_b2b();
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule